// File: doc/BRIEF.md
# Serializer with Per-Slot Tri-State Mask

This block turns a parallel word into a serial bit stream for one output lane and sends an output-enable stream with it. A wrapper turns the enable stream into a high-impedance state on a tri-state pad. Each word is either eight or four bits long. A four-bit slot mask is captured and shifted with the data, so single bit slots inside a word can be released to Z while the other slots of the same word stay driven.

The word width, the tri-state source and the tri-state values are all captured together with the data on a load strobe. A second mode drops the mask and uses one word-wide tri-state input for every slot of the word. A word loaded while another is still going out waits in a holding register. It starts at the next word boundary, so a word is never cut short. When nothing is pending at a boundary the lane goes quiet.

Top module: `slot_mask_serializer`

## Requirements
- R1: After a synchronous active-low reset, `ser_oe` and `ser_out` are both 0. They stay 0 until the first slot of the first loaded word is presented.
- R2: When the lane is idle, a word whose `load` is sampled high on rising edge k presents its first slot from edge k+1. It then presents one slot per clock cycle.
- R3: With `wide_sel`=1 the word has eight slots, sent from slot 7 down to slot 0. Slot s carries `par_data[s]`. In per-slot mode, mask bit i governs slots 2i and 2i+1. A mask bit of 1 drives those slots and a mask bit of 0 makes them Z. Examples: mask 1111 with all-ones data gives 11111111. Mask 1010 with all-ones data gives 11ZZ11ZZ. Mask 1101 with all-zeros data gives 0000ZZ00.
- R4: With `wide_sel`=0 the word has four slots, sent from slot 3 down to slot 0. Slot s carries `par_data[s]`, and mask bit i governs slot i alone. `par_data[7:4]` has no effect.
- R5: With `slot_mode`=0 the mask has no effect. Every slot of the word is driven when `word_hiz`=0 and is Z when `word_hiz`=1. With `slot_mode`=1 the mask rules of R3 and R4 apply.
- R6: Data, mask, `word_hiz`, `wide_sel` and `slot_mode` are all sampled on the same load edge. Each slot's enable appears in the same cycle as that slot's data bit.
- R7: If the next `load` is sampled no later than the edge that presents the current word's last slot, the next word's first slot follows the last slot directly, with no idle cycle.
- R8: The word being sent is always sent in full. When several loads arrive during one word, only the most recent one is sent next, and the earlier ones are dropped.
- R9: If no word is pending when the last slot ends, then from the next cycle `ser_oe`=0 and `ser_out`=0 until another word starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Capture strobe for word, mask and mode |
| wide_sel | input | 1 | 1: eight-slot word, 0: four-slot word |
| slot_mode | input | 1 | 1: per-slot mask, 0: word-wide tri-state |
| par_data | input | 8 | Parallel data word |
| slot_mask | input | 4 | Per-slot drive mask, 1 = driven |
| word_hiz | input | 1 | Word-wide tri-state request, 1 = Z |
| ser_out | output | 1 | Serial data bit |
| ser_oe | output | 1 | Serial output enable, 1 = pad driven |

## Verification
The bench sends every mask value with several data patterns in both word widths. It compares the resolved pad symbol (0, 1 or Z) slot by slot. A design that mapped mask bits to the wrong slot pairs, or reversed the slot order, would put Z on the wrong slots. A design whose enable ran one cycle off its data would also do this. A narrow word that leaked `par_data[7:4]` would show upper bits. Word mode is swept with masks that would produce holes if they were wrongly honoured. Back-to-back and repeated loads check that no gap appears between words, that no word is cut short, and that only the latest pending word follows. The bench also checks that a design which failed to quiet the lane after the last word would be caught.

// File: rtl/sms_pkg.sv
// Package: shared configuration for the slot-mask serializer.
// Assumes one mask bit per narrow slot and words twice the mask width.
package sms_pkg;

    localparam int unsigned SMS_MASK_W = 4;

    // Per-word configuration captured with the data.
    typedef struct packed {
        logic wide;      // 1: word of 2*MASK_W slots, 0: word of MASK_W slots
        logic per_slot;  // 1: serialized mask, 0: word-wide tri-state
    } word_cfg_t;

endpackage

// File: rtl/sms_word_align.sv
// Module: sms_word_align
// Places an incoming word and its per-slot enables into lanes with the
// first slot at the top bit. Narrow words sit in the upper half.
// Assumes WIDE_W = 2*MASK_W. Purely combinational.
module sms_word_align #(
    parameter int unsigned MASK_W = 4
) (
    input  logic [2*MASK_W-1:0] par_data,
    input  logic [MASK_W-1:0]   slot_mask,
    input  sms_pkg::word_cfg_t  cfg,
    input  logic                word_hiz,
    output logic [2*MASK_W-1:0] al_data,
    output logic [2*MASK_W-1:0] al_en
);
    localparam int unsigned WIDE_W   = 2 * MASK_W;
    localparam int unsigned NARROW_W = MASK_W;

    logic [WIDE_W-1:0] wide_en;
    logic [WIDE_W-1:0] nar_en;
    logic [WIDE_W-1:0] nar_data;
    logic [WIDE_W-1:0] word_en;

    // Wide words: each mask bit covers an adjacent slot pair.
    for (genvar s = 0; s < WIDE_W; s++) begin : g_wide
        assign wide_en[s] = slot_mask[s/2];
    end

    // Narrow words: one mask bit per slot, shifted into the upper half.
    for (genvar s = 0; s < NARROW_W; s++) begin : g_narrow
        assign nar_en[s+NARROW_W]   = slot_mask[s];
        assign nar_data[s+NARROW_W] = par_data[s];
        assign nar_en[s]            = 1'b0;
        assign nar_data[s]          = 1'b0;
    end

    // Select the data lanes and the enable source for this word.
    always_comb begin
        al_data = cfg.wide ? par_data : nar_data;
        word_en = cfg.wide ? {WIDE_W{1'b1}} : {{NARROW_W{1'b1}}, {NARROW_W{1'b0}}};
        if (cfg.per_slot) begin
            al_en = cfg.wide ? wide_en : nar_en;
        end else begin
            al_en = word_hiz ? '0 : word_en;
        end
    end

endmodule

// File: rtl/sms_shift_lane.sv
// Module: sms_shift_lane
// One MSB-first shift register. It loads a whole word, shifts left by one
// slot per cycle, or clears to zero when the lane goes idle.
// Assumes the control inputs are mutually exclusive in priority order.
module sms_shift_lane #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         drain,
    input  logic         advance,
    input  logic [W-1:0] load_vec,
    output logic         lane_msb
);
    logic [W-1:0] vec;

    // Load, clear or shift the lane once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec <= '0;
        end else if (take) begin
            vec <= load_vec;
        end else if (drain) begin
            vec <= '0;
        end else if (advance) begin
            vec <= {vec[W-2:0], 1'b0};
        end
    end

    assign lane_msb = vec[W-1];

endmodule

// File: rtl/sms_frame_ctrl.sv
// Module: sms_frame_ctrl
// Word framing: keeps one pending word, counts slots of the active word,
// and hands the pending word over only at a word boundary or when idle.
// Assumes NARROW_W <= WIDE_W.
module sms_frame_ctrl #(
    parameter int unsigned WIDE_W   = 8,
    parameter int unsigned NARROW_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  sms_pkg::word_cfg_t load_cfg,
    output logic               take,
    output logic               advance,
    output logic               drain,
    output logic               busy,
    output sms_pkg::word_cfg_t cur_cfg
);
    localparam int unsigned      CNT_W       = $clog2(WIDE_W);
    localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_W - 1);
    localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_W - 1);
    localparam logic [CNT_W-1:0] CNT_ZERO    = '0;
    localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);

    logic               hold_valid;
    sms_pkg::word_cfg_t hold_cfg;
    logic [CNT_W-1:0]   cnt;
    logic               last_slot;

    assign last_slot = busy && (cnt == CNT_ZERO);
    assign take      = hold_valid && (!busy || last_slot);
    assign advance   = busy && !last_slot;
    assign drain     = last_slot && !hold_valid;

    // Pending-word flag: a new load overwrites, a hand-over empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_cfg   <= '0;
        end else if (load) begin
            hold_valid <= 1'b1;
            hold_cfg   <= load_cfg;
        end else if (take) begin
            hold_valid <= 1'b0;
        end
    end

    // Slot counter of the active word, counting down to the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= CNT_ZERO;
            cur_cfg <= '0;
        end else if (take) begin
            busy    <= 1'b1;
            cnt     <= hold_cfg.wide ? WIDE_LAST : NARROW_LAST;
            cur_cfg <= hold_cfg;
        end else if (last_slot) begin
            busy    <= 1'b0;
        end else if (busy) begin
            cnt     <= cnt - CNT_ONE;
        end
    end

    // R3/R4: the counter never exceeds the active word's last slot.
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= (cur_cfg.wide ? WIDE_LAST : NARROW_LAST)));

    // R2: an idle lane with a pending word starts it at the next edge.
    p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hold_valid) |=>
            (busy && cnt == ($past(hold_cfg.wide) ? WIDE_LAST : NARROW_LAST)));

    // R7: a word pending at the last slot follows with no gap.
    p_seamless_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == CNT_ZERO && hold_valid) |=>
            (busy && cnt == ($past(hold_cfg.wide) ? WIDE_LAST : NARROW_LAST)));

    // R8: a word in progress is never cut short, even by a new load.
    p_no_partial_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != CNT_ZERO) |=> (busy && cnt == $past(cnt) - CNT_ONE));

    // R9: with nothing pending, the lane goes idle after the last slot.
    p_drain_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == CNT_ZERO && !hold_valid) |=> !busy);

endmodule

// File: rtl/slot_mask_serializer.sv
// Module: slot_mask_serializer (top)
// Serializes an eight- or four-slot word MSB first, together with a
// per-slot output-enable stream taken either from a serialized mask or
// from a word-wide tri-state input. A pad wrapper turns ser_oe low into Z.
// Assumes load is synchronous to clk; all word settings are taken at load.
module slot_mask_serializer #(
    parameter int unsigned MASK_W = sms_pkg::SMS_MASK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                wide_sel,
    input  logic                slot_mode,
    input  logic [2*MASK_W-1:0] par_data,
    input  logic [MASK_W-1:0]   slot_mask,
    input  logic                word_hiz,
    output logic                ser_out,
    output logic                ser_oe
);
    localparam int unsigned WIDE_W   = 2 * MASK_W;
    localparam int unsigned NARROW_W = MASK_W;

    sms_pkg::word_cfg_t in_cfg;
    sms_pkg::word_cfg_t cur_cfg;
    logic [WIDE_W-1:0]  al_data;
    logic [WIDE_W-1:0]  al_en;
    logic [WIDE_W-1:0]  hold_data;
    logic [WIDE_W-1:0]  hold_en;
    logic               take;
    logic               advance;
    logic               drain;
    logic               busy;

    assign in_cfg.wide     = wide_sel;
    assign in_cfg.per_slot = slot_mode;

    sms_word_align #(.MASK_W(MASK_W)) align_i (
        .par_data  (par_data),
        .slot_mask (slot_mask),
        .cfg       (in_cfg),
        .word_hiz  (word_hiz),
        .al_data   (al_data),
        .al_en     (al_en)
    );

    // Pending word: data and enables captured together on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_en   <= '0;
        end else if (load) begin
            hold_data <= al_data;
            hold_en   <= al_en;
        end
    end

    sms_frame_ctrl #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_cfg (in_cfg),
        .take     (take),
        .advance  (advance),
        .drain    (drain),
        .busy     (busy),
        .cur_cfg  (cur_cfg)
    );

    sms_shift_lane #(.W(WIDE_W)) data_lane_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .drain    (drain),
        .advance  (advance),
        .load_vec (hold_data),
        .lane_msb (ser_out)
    );

    sms_shift_lane #(.W(WIDE_W)) en_lane_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .drain    (drain),
        .advance  (advance),
        .load_vec (hold_en),
        .lane_msb (ser_oe)
    );

    // R1/R9: an idle lane neither drives the pad nor shows a data one.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_oe && !ser_out));

    // R5: in word mode the enable holds steady within one word.
    p_word_oe_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cur_cfg.per_slot && $past(busy) && !$past(take)) |->
            $stable(ser_oe));

endmodule

// File: tb/slot_mask_serializer_tb_top.sv
`timescale 1ns/1ps
module slot_mask_serializer_tb_top;

    typedef struct packed {
        logic [7:0] d;
        logic [3:0] m;
        logic       w;
        logic       md;
        logic       hz;
    } word_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic       wide_sel = 1'b0;
    logic       slot_mode = 1'b0;
    logic [7:0] par_data = '0;
    logic [3:0] slot_mask = '0;
    logic       word_hiz = 1'b0;
    logic       ser_out;
    logic       ser_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    slot_mask_serializer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .wide_sel  (wide_sel),
        .slot_mode (slot_mode),
        .par_data  (par_data),
        .slot_mask (slot_mask),
        .word_hiz  (word_hiz),
        .ser_out   (ser_out),
        .ser_oe    (ser_oe)
    );

    // Resolved pad symbol as the wrapper would present it.
    function automatic byte pad_sym();
        if (!ser_oe) return "Z";
        return ser_out ? "1" : "0";
    endfunction

    // Expected symbol of slot s, computed from the requirements.
    function automatic byte exp_sym(word_t x, int s);
        logic en;
        if (x.md) en = x.w ? x.m[s/2] : x.m[s];
        else      en = !x.hz;
        if (!en) return "Z";
        return x.d[s] ? "1" : "0";
    endfunction

    function automatic int wsize(word_t x);
        return x.w ? 8 : 4;
    endfunction

    task automatic chk(byte act, byte exp, string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %c expected %c at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply(word_t x, logic ld);
        par_data  = x.d;
        slot_mask = x.m;
        wide_sel  = x.w;
        slot_mode = x.md;
        word_hiz  = x.hz;
        load      = ld;
    endtask

    // R9: idle lane, checked as symbol and as raw data bit.
    task automatic chk_idle(string tag);
        chk(pad_sym(), "Z", tag);
        chk(ser_out ? "1" : "0", "0", tag);
    endtask

    // Single word from idle: latency, slot order, enables, then idle.
    task automatic run_word(word_t x, string tag);
        @(negedge clk); apply(x, 1'b1);
        @(negedge clk); load = 1'b0;
        chk_idle("R2 pre-start");
        for (int s = wsize(x) - 1; s >= 0; s--) begin
            @(negedge clk);
            chk(pad_sym(), exp_sym(x, s), (s == wsize(x) - 1) ? "R2 first slot" : tag);
        end
        @(negedge clk);
        chk_idle("R9");
    endtask

    // Word a, then b loaded at a's first slot; c (if used) two cycles later.
    task automatic run_stream(word_t a, word_t b, word_t c, bit use_c, string tag);
        word_t nxt;
        int    k;
        nxt = use_c ? c : b;
        @(negedge clk); apply(a, 1'b1);
        @(negedge clk); load = 1'b0;
        k = 0;
        for (int s = wsize(a) - 1; s >= 0; s--) begin
            @(negedge clk);
            chk(pad_sym(), exp_sym(a, s), tag);
            if (k == 0) apply(b, 1'b1);
            else if (k == 1) load = 1'b0;
            else if (k == 2 && use_c) apply(c, 1'b1);
            else if (k == 3) load = 1'b0;
            k++;
        end
        for (int s = wsize(nxt) - 1; s >= 0; s--) begin
            @(negedge clk);
            load = 1'b0;
            chk(pad_sym(), exp_sym(nxt, s), tag);
        end
        @(negedge clk);
        chk_idle("R9 after stream");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        word_t x, y, z;
        byte   pats [4];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset with no load.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_idle("R1");
        end

        // R3: the three example vectors.
        x = '{d: 8'hFF, m: 4'b1111, w: 1'b1, md: 1'b1, hz: 1'b0}; run_word(x, "R3 1111");
        x = '{d: 8'hFF, m: 4'b1010, w: 1'b1, md: 1'b1, hz: 1'b0}; run_word(x, "R3 1010");
        x = '{d: 8'h00, m: 4'b1101, w: 1'b1, md: 1'b1, hz: 1'b0}; run_word(x, "R3 1101");

        // R3/R6: every mask, several data patterns, eight-slot words.
        pats = '{8'hFF, 8'h00, 8'hA5, 8'h3C};
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 4; p++) begin
                x = '{d: pats[p] ^ 8'(m * 17), m: 4'(m), w: 1'b1, md: 1'b1, hz: 1'b0};
                run_word(x, "R3/R6 wide");
            end
        end

        // R4: every mask, four-slot words, upper data bits set to differ.
        pats = '{8'hF0, 8'h0F, 8'h5A, 8'hC3};
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 4; p++) begin
                x = '{d: pats[p], m: 4'(m), w: 1'b0, md: 1'b1, hz: 1'b0};
                run_word(x, "R4 narrow");
            end
        end

        // R5: word mode ignores the mask.
        for (int w = 0; w < 2; w++) begin
            for (int h = 0; h < 2; h++) begin
                for (int m = 0; m < 3; m++) begin
                    x = '{d: (m == 1) ? 8'hA5 : 8'h3C,
                          m: (m == 0) ? 4'h0 : ((m == 1) ? 4'hF : 4'h6),
                          w: 1'(w), md: 1'b0, hz: 1'(h)};
                    run_word(x, "R5 word mode");
                end
            end
        end

        // R7: back-to-back words of mixed width and mode.
        x = '{d: 8'hC5, m: 4'b0110, w: 1'b1, md: 1'b1, hz: 1'b0};
        y = '{d: 8'h09, m: 4'b1011, w: 1'b0, md: 1'b1, hz: 1'b0};
        run_stream(x, y, y, 1'b0, "R7 wide->narrow");
        x = '{d: 8'h0A, m: 4'b0101, w: 1'b0, md: 1'b1, hz: 1'b0};
        y = '{d: 8'h96, m: 4'b0000, w: 1'b1, md: 1'b0, hz: 1'b0};
        run_stream(x, y, y, 1'b0, "R7 narrow->wide");

        // R8: second load overwrites the pending word; current finishes.
        x = '{d: 8'hFF, m: 4'b1001, w: 1'b1, md: 1'b1, hz: 1'b0};
        y = '{d: 8'h00, m: 4'b1111, w: 1'b1, md: 1'b1, hz: 1'b0};
        z = '{d: 8'h6B, m: 4'b0111, w: 1'b1, md: 1'b1, hz: 1'b0};
        run_stream(x, y, z, 1'b1, "R8 overwrite");
        x = '{d: 8'h0D, m: 4'b1111, w: 1'b0, md: 1'b0, hz: 1'b1};
        y = '{d: 8'hFF, m: 4'b1111, w: 1'b1, md: 1'b1, hz: 1'b0};
        z = '{d: 8'h05, m: 4'b1110, w: 1'b0, md: 1'b1, hz: 1'b0};
        run_stream(x, y, z, 1'b1, "R8 overwrite narrow");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule